// File: doc/BRIEF.md
# Branch Record Ring with Interrupt Freeze

This block keeps a circular history of the most recent control-flow transfers: taken branches, interrupts and exceptions. Each event presents a source address and a destination address for one cycle. When recording is enabled, the block advances a newest-entry pointer around a ring of parameterised depth and writes the pair at the new position. The newest transfer is therefore always the one the pointer selects.

Recording is gated by an enable bit in a control register. A performance-monitor interrupt request clears that bit in hardware, so the history stays fixed while the interrupt handler examines it. The block never sets the bit again by itself; software has to write it back to 1. A small register port lets software read the control register, the pointer, every stored pair and a read-only field that reports the address record format. The format is chosen at build time: a 32-bit segment offset, a 64-bit linear address, or a 64-bit effective address.

Top module: `branch_ring_top`

## Requirements
- R1: After reset the enable bit reads 0, the pointer reads 0 and every stored source and destination address reads 0.
- R2: An event that arrives while the enable bit is 1 first moves the pointer one step forward, modulo DEPTH, and then stores the pair at the new pointer value.
- R3: The pointer never exceeds DEPTH-1. An event recorded at position DEPTH-1 moves it to 0, and that event overwrites the oldest entry.
- R4: An event that arrives while the enable bit is 0 changes neither the pointer nor any stored entry.
- R5: A cycle with the interrupt request high clears the enable bit. The bit then stays 0, and further events are ignored, until software writes 1 to bit 0 of the control register.
- R6: An event that arrives in the same cycle as the interrupt request, while recording is enabled, is still recorded. The enable bit reads 0 afterwards.
- R7: A software write to the control register in the same cycle as the interrupt request loses: the enable bit reads 0 afterwards, even when the write sets it to 1.
- R8: The capability register at address 0x02 is read-only. Its bits 5:0 hold the format code: 0 for a 32-bit segment offset, 1 for a 64-bit linear address, 2 for a 64-bit effective address. All other bits read 0, and writes have no effect.
- R9: With the 32-bit format, each stored address keeps bits 31:0 of the captured value, and bits 63:32 read 0.
- R10: The register map is as follows. Address 0x00 is the control register, with the enable bit at bit 0. Address 0x01 is the pointer, placed in the low bits. Address 0x10+2i holds the source address of entry i, and address 0x11+2i holds its destination address. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A control-flow transfer is presented this cycle |
| ev_src | input | 64 | Source address of the transfer |
| ev_dst | input | 64 | Destination address of the transfer |
| pmi_req | input | 1 | Performance-monitor interrupt request; clears the enable bit |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |

## Verification
Several properties are checked by assertions on every cycle. The pointer stays in range. It holds still whenever recording is off, and it steps by exactly one position when an event is recorded, with the new pair landing at that position. An interrupt request always leaves the enable bit at 0, and the bit can only rise through a software write. The capability readout is also checked continuously. Other behaviours can only be shown by the bench's scenarios, because they involve sequences and values that software observes. These are the wrap-around overwrite of the oldest entry, the race between a control write and an interrupt, the zero-extension of 32-bit records, and the readback of unmapped addresses.

// File: rtl/brr_pkg.sv
package brr_pkg;

    localparam int AW = 8;
    localparam int DW = 64;

    localparam logic [AW-1:0] ADDR_CTRL  = 8'h00;
    localparam logic [AW-1:0] ADDR_PTR   = 8'h01;
    localparam logic [AW-1:0] ADDR_CAP   = 8'h02;
    localparam logic [AW-1:0] ENTRY_BASE = 8'h10;

    typedef enum logic [5:0] {
        FMT_SEG32 = 6'd0,
        FMT_LIN64 = 6'd1,
        FMT_EFF64 = 6'd2
    } fmt_e;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
    } rec_t;

    function automatic logic [DW-1:0] shape_addr(input fmt_e f, input logic [DW-1:0] a);
        return (f == FMT_SEG32) ? {32'b0, a[31:0]} : a;
    endfunction

endpackage

// File: rtl/brr_ctrl.sv
module brr_ctrl (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pmi_req,
    input  logic                 wr_ctrl,
    input  logic                 wr_bit,
    output logic                 rec_en
);
    always_ff @(posedge clk) begin
        if (rst)
            rec_en <= 1'b0;
        else if (pmi_req)
            rec_en <= 1'b0;
        else if (wr_ctrl)
            rec_en <= wr_bit;
    end

    // R5 R7
    freeze_clears_chk: assert property (@(posedge clk) disable iff (rst)
        pmi_req |=> !rec_en);

    // R5
    no_self_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (!rec_en && !(wr_ctrl && wr_bit)) |=> !rec_en);

endmodule

// File: rtl/brr_store.sv
module brr_store
    import brr_pkg::*;
#(
    parameter int   DEPTH = 8,
    parameter fmt_e FMT   = FMT_LIN64,
    localparam int  PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rec_en,
    input  logic                    ev_valid,
    input  logic [DW-1:0]           ev_src,
    input  logic [DW-1:0]           ev_dst,
    output logic [PW-1:0]           tos,
    output rec_t [DEPTH-1:0]        ring
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] tos_nxt;
    rec_t          incoming;

    always_comb begin
        tos_nxt      = (tos == LAST) ? '0 : tos + 1'b1;
        incoming.src = shape_addr(FMT, ev_src);
        incoming.dst = shape_addr(FMT, ev_dst);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos  <= '0;
            ring <= '0;
        end else if (ev_valid && rec_en) begin
            tos            <= tos_nxt;
            ring[tos_nxt]  <= incoming;
        end
    end

    // R3
    tos_range_chk: assert property (@(posedge clk) disable iff (rst)
        tos <= LAST);

    // R4
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !rec_en |=> ($stable(tos) && $stable(ring)));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && rec_en) |=>
            (tos == (($past(tos) == LAST) ? '0 : $past(tos) + 1'b1)));

    // R2 R9
    newest_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && rec_en) |=>
            (ring[tos].src == shape_addr(FMT, $past(ev_src)) &&
             ring[tos].dst == shape_addr(FMT, $past(ev_dst))));

endmodule

// File: rtl/brr_regs.sv
module brr_regs
    import brr_pkg::*;
#(
    parameter int   DEPTH = 8,
    parameter fmt_e FMT   = FMT_LIN64,
    localparam int  PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]     reg_addr,
    input  logic              rec_en,
    input  logic [PW-1:0]     tos,
    input  rec_t [DEPTH-1:0]  ring,
    output logic [DW-1:0]     rdata
);
    localparam int SPAN = 2 * DEPTH;

    logic [AW-1:0] off;
    logic [PW-1:0] idx;
    logic          in_ring;

    always_comb begin
        off     = reg_addr - ENTRY_BASE;
        idx     = off[PW:1];
        in_ring = (reg_addr >= ENTRY_BASE) && (int'(off) < SPAN);
        rdata   = '0;
        if (reg_addr == ADDR_CTRL)
            rdata = {{(DW-1){1'b0}}, rec_en};
        else if (reg_addr == ADDR_PTR)
            rdata = {{(DW-PW){1'b0}}, tos};
        else if (reg_addr == ADDR_CAP)
            rdata = {{(DW-6){1'b0}}, FMT};
        else if (in_ring)
            rdata = off[0] ? ring[idx].dst : ring[idx].src;
    end

    // R8
    always_comb begin
        if (reg_addr == ADDR_CAP)
            cap_value_chk: assert (rdata[5:0] == FMT && rdata[DW-1:6] == '0);
    end

endmodule

// File: rtl/branch_ring_top.sv
module branch_ring_top
    import brr_pkg::*;
#(
    parameter int   DEPTH = 8,
    parameter fmt_e FMT   = FMT_LIN64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    input  logic [63:0]   ev_src,
    input  logic [63:0]   ev_dst,
    input  logic          pmi_req,
    input  logic [7:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [63:0]   reg_wdata,
    output logic [63:0]   reg_rdata
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             rec_en;
    logic [PW-1:0]    tos;
    rec_t [DEPTH-1:0] ring;

    brr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .pmi_req (pmi_req),
        .wr_ctrl (reg_wr && (reg_addr == ADDR_CTRL)),
        .wr_bit  (reg_wdata[0]),
        .rec_en  (rec_en)
    );

    brr_store #(.DEPTH(DEPTH), .FMT(FMT)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rec_en   (rec_en),
        .ev_valid (ev_valid),
        .ev_src   (ev_src),
        .ev_dst   (ev_dst),
        .tos      (tos),
        .ring     (ring)
    );

    brr_regs #(.DEPTH(DEPTH), .FMT(FMT)) u_regs (
        .reg_addr (reg_addr),
        .rec_en   (rec_en),
        .tos      (tos),
        .ring     (ring),
        .rdata    (reg_rdata)
    );

endmodule

// File: tb/sim_branch_ring_top.sv
module sim_branch_ring_top;
    import brr_pkg::*;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_valid, pmi_req, reg_wr;
    logic [63:0] ev_src, ev_dst, reg_wdata;
    logic [7:0]  reg_addr;
    logic [63:0] rd0, rd1;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_ptr = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    branch_ring_top #(.DEPTH(DEPTH), .FMT(FMT_LIN64)) u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_src(ev_src), .ev_dst(ev_dst),
        .pmi_req(pmi_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rd0));

    branch_ring_top #(.DEPTH(DEPTH), .FMT(FMT_SEG32)) u1 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_src(ev_src), .ev_dst(ev_dst),
        .pmi_req(pmi_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rd1));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, capture at the following posedge
    task automatic cycle(input logic ev, input logic [63:0] s, input logic [63:0] d,
                         input logic pmi, input logic wr, input logic [7:0] a,
                         input logic [63:0] wd);
        @(negedge clk);
        ev_valid = ev; ev_src = s; ev_dst = d; pmi_req = pmi;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        ev_valid = 0; pmi_req = 0; reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        reg_addr = a;
        #1;
    endtask

    function automatic logic [7:0] src_a(input int i); return 8'h10 + 8'(2*i); endfunction
    function automatic logic [7:0] dst_a(input int i); return 8'h11 + 8'(2*i); endfunction

    task automatic event_in(input logic [63:0] s, input logic [63:0] d);
        cycle(1, s, d, 0, 0, 8'h00, 0);
    endtask

    task automatic t_reset;
        rd(8'h00); chk("R1 ctrl", rd0, 0);
        rd(8'h01); chk("R1 ptr", rd0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(src_a(i)); chk("R1 src", rd0, 0);
            rd(dst_a(i)); chk("R1 dst", rd0, 0);
        end
    endtask

    task automatic t_disabled;
        event_in(64'hAAAA_0000_1111_2222, 64'hBBBB_0000_3333_4444);
        rd(8'h01);     chk("R4 ptr", rd0, 0);
        rd(src_a(1));  chk("R4 src", rd0, 0);
        rd(dst_a(1));  chk("R4 dst", rd0, 0);
    endtask

    task automatic t_record;
        cycle(0, 0, 0, 0, 1, 8'h00, 64'h1);
        rd(8'h00); chk("R5 ctrl set", rd0, 1);
        event_in(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        exp_ptr = 1;
        rd(8'h01);    chk("R2 ptr", rd0, 64'(exp_ptr));
        rd(src_a(1)); chk("R2 src", rd0, 64'h1234_5678_9ABC_DEF0);
        rd(dst_a(1)); chk("R2 dst", rd0, 64'h0FED_CBA9_8765_4321);
        rd(src_a(0)); chk("R2 older slot", rd0, 0);
    endtask

    task automatic t_wrap;
        for (int k = 2; k <= DEPTH; k++) begin
            event_in(64'h100 + 64'(k), 64'h200 + 64'(k));
            exp_ptr = (exp_ptr + 1) % DEPTH;
        end
        rd(8'h01);            chk("R3 ptr wrap", rd0, 0);
        rd(src_a(0));         chk("R3 overwrite src", rd0, 64'h100 + 64'(DEPTH));
        rd(dst_a(0));         chk("R3 overwrite dst", rd0, 64'h200 + 64'(DEPTH));
        rd(src_a(DEPTH-1));   chk("R3 last slot", rd0, 64'h100 + 64'(DEPTH-1));
        event_in(64'h5A5A, 64'hA5A5);
        exp_ptr = 1;
        rd(8'h01);            chk("R3 ptr after wrap", rd0, 1);
    endtask

    task automatic t_freeze;
        cycle(0, 0, 0, 1, 0, 8'h00, 0);
        rd(8'h00); chk("R5 cleared", rd0, 0);
        event_in(64'hDEAD, 64'hBEEF);
        rd(8'h01); chk("R5 frozen ptr", rd0, 64'(exp_ptr));
        rd(src_a(2)); chk("R5 frozen entry", rd0, 64'h102);
        repeat (5) @(negedge clk);
        rd(8'h00); chk("R5 stays off", rd0, 0);
        cycle(0, 0, 0, 0, 1, 8'h00, 64'h1);
        rd(8'h00); chk("R5 re-enabled", rd0, 1);
    endtask

    task automatic t_same_cycle;
        cycle(1, 64'hCAFE_0001, 64'hCAFE_0002, 1, 0, 8'h00, 0);
        exp_ptr = (exp_ptr + 1) % DEPTH;
        rd(8'h01);          chk("R6 ptr", rd0, 64'(exp_ptr));
        rd(src_a(exp_ptr)); chk("R6 src", rd0, 64'hCAFE_0001);
        rd(dst_a(exp_ptr)); chk("R6 dst", rd0, 64'hCAFE_0002);
        rd(8'h00);          chk("R6 ctrl", rd0, 0);
    endtask

    task automatic t_race;
        cycle(0, 0, 0, 1, 1, 8'h00, 64'h1);
        rd(8'h00); chk("R7 write loses", rd0, 0);
        cycle(0, 0, 0, 0, 1, 8'h00, 64'h1);
        cycle(0, 0, 0, 1, 1, 8'h00, 64'h1);
        rd(8'h00); chk("R7 from enabled", rd0, 0);
    endtask

    task automatic t_cap;
        rd(8'h02); chk("R8 cap lin64", rd0, 64'd1);
        chk("R8 cap seg32", rd1, 64'd0);
        cycle(0, 0, 0, 0, 1, 8'h02, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h02); chk("R8 cap after write", rd0, 64'd1);
        rd(8'h01); chk("R8 ptr untouched", rd0, 64'(exp_ptr));
    endtask

    task automatic t_zext;
        cycle(0, 0, 0, 0, 1, 8'h00, 64'h1);
        event_in(64'hFEDC_BA98_7654_3210, 64'h8000_0001_C000_0003);
        exp_ptr = (exp_ptr + 1) % DEPTH;
        rd(src_a(exp_ptr));
        chk("R9 seg32 src", rd1, 64'h0000_0000_7654_3210);
        chk("R9 lin64 src", rd0, 64'hFEDC_BA98_7654_3210);
        rd(dst_a(exp_ptr));
        chk("R9 seg32 dst", rd1, 64'h0000_0000_C000_0003);
    endtask

    task automatic t_map;
        rd(8'h03);                 chk("R10 hole", rd0, 0);
        rd(8'h10 + 8'(2*DEPTH));   chk("R10 past ring", rd0, 0);
        rd(8'hFF);                 chk("R10 top addr", rd0, 0);
        rd(8'h01);                 chk("R10 ptr addr", rd0, 64'(exp_ptr));
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; ev_valid = 0; pmi_req = 0; reg_wr = 0;
        ev_src = 0; ev_dst = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_disabled();
        t_record();
        t_wrap();
        t_freeze();
        t_same_cycle();
        t_race();
        t_cap();
        t_zext();
        t_map();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule